// File: doc/BRIEF.md
# Serial-line frame CRC-16 unit

This block computes the 16-bit cyclic redundancy check used on byte-oriented serial-line frames. The register is reflected (least significant bit first) and starts each frame at all ones. Message bytes arrive over a valid/ready byte interface. A start-of-frame strobe reloads the register, and an end-of-message flag goes with the last byte. The unit works one bit per clock, so each accepted byte keeps the input stalled for eight cycles.

In generate mode the unit reports the final CRC and then emits its two bytes, low byte first, ready to be appended to the outgoing frame. In check mode the caller feeds in the whole received frame, including the trailing two CRC bytes in their transmitted order. The unit runs the CRC over everything. A correct frame leaves a zero residue, and any other residue raises an error flag.

Top module: `crc16_serial`

## Requirements
- R1: A one-cycle pulse on `sof` with no byte accepted in that cycle leaves `crc_out` at 0xFFFF from the next cycle on. It also clears `crc_error`.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high. After an accept, `in_ready` stays low for eight cycles and returns high after the eighth shift.
- R3: Each accepted byte is XORed into bits 7:0 of the register. Then follow eight steps of shifting one place toward bit 0 with zero into bit 15. Whenever the bit shifted out is 1, the shifted value is XORed with 0xA001.
- R4: The register carries over between bytes of a frame. For the message 0x0D 0x01 0x00 0x62 0x00 0x33 the final `crc_out` is 0x0DDD.
- R5: When a byte is accepted with `in_eom` high, `done` is high for exactly one cycle, the cycle after its eighth shift. `crc_out` then holds the final value.
- R6: In generate mode (`mode`=0 when the last byte is accepted), `out_valid` is high in the `done` cycle with `out_data` = CRC bits 7:0. In the next cycle `out_valid` is high with CRC bits 15:8. At all other times `out_valid` is low.
- R7: In check mode (`mode`=1), `crc_error` is set in the `done` cycle exactly when the residue over all bytes is non-zero. Equivalently, it is set when the last two bytes, read as {last, second-to-last}, differ from the CRC of the bytes before them. No output bytes are emitted in check mode.
- R8: `crc_error` keeps its value until the next `sof`.
- R9: A `sof` pulse during a shift sequence aborts it: `crc_out` returns to 0xFFFF, `in_ready` goes high, and no `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 generate, 1 check; sampled with each accepted byte |
| sof | input | 1 | Start-of-frame strobe, reloads the register |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input data byte |
| in_eom | input | 1 | Marks the byte as the last of the message |
| in_ready | output | 1 | High when a byte can be accepted |
| crc_out | output | 16 | Current CRC register value |
| done | output | 1 | One-cycle pulse after the last byte is processed |
| out_valid | output | 1 | CRC byte output valid (generate mode) |
| out_data | output | 8 | CRC byte, low byte first |
| crc_error | output | 1 | Check-mode mismatch flag |

## Verification
The bench sweeps every single-byte value in both modes. Data bits that are 1 in the LSB position exercise the feedback XOR, so a wrong constant, a wrong shift direction or a missing step shows up as a wrong CRC on at least one value. It runs the six-byte reference message and flips each bit of the appended frame in turn. A unit that swapped the trailing byte order or compared the wrong bytes would then miss errors or flag good frames. Further checks cover the exact eight-cycle stall, the one-cycle `done` timing and the low-then-high byte order. They also cover an abort by `sof` in the middle of a byte, where a unit that finished the byte anyway would pulse `done` or leave a stale register.

// File: rtl/crc16_serial.sv
module crc16_serial #(
  parameter logic [15:0] POLY = 16'hA001,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode,
  input  logic        sof,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_eom,
  output logic        in_ready,
  output logic [15:0] crc_out,
  output logic        done,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        crc_error
);

  logic [15:0] crc;
  logic [3:0]  cnt;
  logic        last, mode_q, hi_pend;
  logic        accept;
  logic [15:0] nxt;

  assign in_ready = (cnt == 4'd0) && !hi_pend;
  assign accept   = in_valid && in_ready;
  assign nxt      = {1'b0, crc[15:1]} ^ (crc[0] ? POLY : 16'h0000);
  assign crc_out  = crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc       <= INIT;
      cnt       <= 4'd0;
      last      <= 1'b0;
      mode_q    <= 1'b0;
      hi_pend   <= 1'b0;
      done      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      crc_error <= 1'b0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      if (hi_pend) begin
        out_valid <= 1'b1;
        out_data  <= crc[15:8];
        hi_pend   <= 1'b0;
      end
      if (sof) begin
        crc       <= INIT;
        cnt       <= 4'd0;
        last      <= 1'b0;
        crc_error <= 1'b0;
      end
      if (accept) begin
        crc    <= (sof ? INIT : crc) ^ {8'h00, in_data};
        cnt    <= 4'd8;
        last   <= in_eom;
        mode_q <= mode;
      end else if (!sof && cnt != 4'd0) begin
        crc <= nxt;
        cnt <= cnt - 4'd1;
        if (cnt == 4'd1 && last) begin
          done <= 1'b1;
          last <= 1'b0;
          if (mode_q) crc_error <= (nxt != 16'h0000);
          else begin
            out_valid <= 1'b1;
            out_data  <= nxt[7:0];
            hi_pend   <= 1'b1;
          end
        end
      end
    end
  end

  assert_sof_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !accept) |=> (crc_out == INIT && !crc_error));

  assert_stall_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  assert_low_byte_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_valid) |-> (out_data == crc_out[7:0]));

  assert_high_byte_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_valid) |=> (out_valid && out_data == $past(crc_out[15:8]) && !done));

  assert_error_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_error) |-> done);

  assert_no_output_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && crc_error) |-> !out_valid);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_crc16_serial.sv
module tb_crc16_serial;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, sof = 1'b0, in_valid = 1'b0, in_eom = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, done, out_valid, crc_error;
  logic [15:0] crc_out;
  logic [7:0]  out_data;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] buf_b [0:15];

  always #5 clk = ~clk;

  crc16_serial dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sof(sof), .in_valid(in_valid),
    .in_data(in_data), .in_eom(in_eom), .in_ready(in_ready), .crc_out(crc_out),
    .done(done), .out_valid(out_valid), .out_data(out_data), .crc_error(crc_error)
  );

  function automatic logic [15:0] upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) c = upd(c, buf_b[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof = 1'b1;
    @(posedge clk); #1 sof = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit eom, input bit m);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_eom = eom; mode = m;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_eom = 1'b0;
  endtask

  task automatic frame(input int n, input bit m, input bit chk_crc);
    logic [15:0] e;
    bit ee;
    e = crc_of(n);
    ee = (e != 16'h0000);
    pulse_sof();
    for (int i = 0; i < n; i++) send(buf_b[i], i == n - 1, m);
    repeat (7) @(posedge clk);
    #1 chk(!done, "R5 done early", {31'd0, done}, 32'd0);
    @(posedge clk); #1;
    chk(done, "R5 done pulse", {31'd0, done}, 32'd1);
    if (chk_crc) chk(crc_out == e, "R3 crc value", {16'd0, crc_out}, {16'd0, e});
    if (!m) begin
      chk(out_valid && out_data == e[7:0], "R6 low byte", {23'd0, out_valid, out_data}, {23'd1, e[7:0]});
      @(posedge clk); #1;
      chk(out_valid && out_data == e[15:8] && !done, "R6 high byte",
          {22'd0, done, out_valid, out_data}, {23'd1, e[15:8]});
      @(posedge clk); #1;
      chk(!out_valid, "R6 output idle", {31'd0, out_valid}, 32'd0);
    end else begin
      chk(crc_error == ee && !out_valid, "R7 check result", {30'd0, out_valid, crc_error}, {31'd0, ee});
      @(posedge clk); #1;
      chk(!out_valid, "R7 no output bytes", {31'd0, out_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    logic [15:0] s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 chk(crc_out == 16'hFFFF && in_ready && !done && !out_valid && !crc_error,
           "R1 reset state", {11'd0, crc_out, in_ready, done, out_valid, crc_error},
           {11'd0, 16'hFFFF, 4'b1000});

    // R2: exact stall window
    pulse_sof();
    chk(crc_out == 16'hFFFF, "R1 sof load", {16'd0, crc_out}, 32'h0000FFFF);
    send(8'h5A, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      chk(!in_ready, "R2 stall", {31'd0, in_ready}, 32'd0);
      @(posedge clk); #1;
    end
    chk(in_ready, "R2 ready again", {31'd0, in_ready}, 32'd1);
    buf_b[0] = 8'h5A;
    chk(crc_out == crc_of(1), "R3 intermediate", {16'd0, crc_out}, {16'd0, crc_of(1)});

    // R4: reference message
    buf_b[0] = 8'h0D; buf_b[1] = 8'h01; buf_b[2] = 8'h00;
    buf_b[3] = 8'h62; buf_b[4] = 8'h00; buf_b[5] = 8'h33;
    frame(6, 1'b0, 1'b1);
    chk(crc_out == 16'h0DDD, "R4 reference crc", {16'd0, crc_out}, 32'h00000DDD);

    // R3: every single-byte frame, generate mode
    for (int v = 0; v < 256; v++) begin
      buf_b[0] = v[7:0];
      frame(1, 1'b0, 1'b1);
    end

    // R7: every single-byte frame with correct and with corrupted appended CRC
    for (int v = 0; v < 256; v++) begin
      buf_b[0] = v[7:0];
      c = crc_of(1);
      buf_b[1] = c[7:0]; buf_b[2] = c[15:8];
      frame(3, 1'b1, 1'b0);
      buf_b[1] = c[15:8]; buf_b[2] = c[7:0];
      if (c[7:0] != c[15:8]) frame(3, 1'b1, 1'b0);
    end

    // R7: reference frame good, then every single-bit corruption
    buf_b[0] = 8'h0D; buf_b[1] = 8'h01; buf_b[2] = 8'h00;
    buf_b[3] = 8'h62; buf_b[4] = 8'h00; buf_b[5] = 8'h33;
    buf_b[6] = 8'hDD; buf_b[7] = 8'h0D;
    frame(8, 1'b1, 1'b0);
    chk(!crc_error, "R7 good frame", {31'd0, crc_error}, 32'd0);
    for (int bit_i = 0; bit_i < 64; bit_i++) begin
      buf_b[bit_i / 8][bit_i % 8] = ~buf_b[bit_i / 8][bit_i % 8];
      frame(8, 1'b1, 1'b0);
      chk(crc_error, "R7 corrupt frame", {31'd0, crc_error}, 32'd1);
      // R8: error flag held
      repeat (5) @(posedge clk);
      #1 chk(crc_error, "R8 error held", {31'd0, crc_error}, 32'd1);
      buf_b[bit_i / 8][bit_i % 8] = ~buf_b[bit_i / 8][bit_i % 8];
    end
    pulse_sof();
    chk(!crc_error, "R8 cleared by sof", {31'd0, crc_error}, 32'd0);

    // R4: multi-byte frames from an LFSR, generate mode
    s = 16'hACE1;
    for (int f = 0; f < 40; f++) begin
      for (int i = 0; i < 1 + (f % 12); i++) begin
        s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        buf_b[i] = s[7:0];
      end
      frame(1 + (f % 12), 1'b0, 1'b1);
    end

    // R9: abort mid-shift
    pulse_sof();
    send(8'hC3, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    pulse_sof();
    chk(crc_out == 16'hFFFF && in_ready, "R9 abort", {15'd0, in_ready, crc_out}, {15'd0, 1'b1, 16'hFFFF});
    for (int k = 0; k < 10; k++) begin
      chk(!done && !out_valid, "R9 no done", {30'd0, done, out_valid}, 32'd0);
      @(posedge clk); #1;
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule